// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the combinational hazard control of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register numbers of the instruction in decode against the destination register numbers of the three older instructions in execute, memory and writeback. For each source it then picks where the operand should come from: the register file, or the newest in-flight result that has not yet been written back.

When the instruction in execute is a load whose destination is a source of the instruction in decode, the loaded data does not exist yet. The unit then requests a one-cycle interlock. The program counter and the decode register hold, and a bubble (a NOP) enters execute. On the next cycle the load has moved to memory and the operand is forwarded from there. When a branch resolved in execute is taken, the unit kills the two younger instructions already fetched, the one in fetch and the one in decode, by turning them into NOPs. A not-taken branch kills nothing.

Register zero is hard-wired and is never treated as a producer. All outputs are a pure function of the current inputs. The datapath muxes, the pipeline registers and the program counter are outside the block and only consume these controls.

Top module: `hzd_fwd_unit`

## Requirements
- R1: For each decode source, `fwd_sel_a` / `fwd_sel_b` encodes the operand origin: 0 = register file, 1 = execute-stage result, 2 = memory-stage result, 3 = writeback-stage result. A stage is a candidate when its write enable is 1 and its destination equals the source number.
- R2: A destination of register zero never produces a forwarding select, a stall or any other match, whatever the enables and the load flag are.
- R3: When several stages are candidates for the same source, the youngest wins: execute over memory over writeback.
- R4: A stage whose write enable is 0 is never selected, even when its destination equals the source.
- R5: A load in execute whose nonzero destination equals source A or source B raises `hold_pc`, `hold_dec` and `bubble_exe` together in the same cycle. All three are always equal.
- R6: A matching non-load in execute is forwarded with no stall. A load in execute whose destination matches neither source causes no stall.
- R7: A taken branch in execute raises both `kill_dec` and `kill_exe`. When no taken branch is in execute, both are 0.
- R8: While `exe_br_taken` is 1, no load-use stall is raised, because the dependent instruction is being killed.
- R9: The select of each source depends only on that source's own number. Changing source B never alters `fwd_sel_a`, and the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_AW | First source register of the instruction in decode |
| dec_src_b | input | REG_AW | Second source register of the instruction in decode |
| exe_dst | input | REG_AW | Destination register of the instruction in execute |
| exe_wen | input | 1 | Register-write enable of the instruction in execute |
| exe_is_load | input | 1 | Instruction in execute is a load |
| exe_br_taken | input | 1 | Branch in execute resolved taken |
| mem_dst | input | REG_AW | Destination register of the instruction in memory |
| mem_wen | input | 1 | Register-write enable of the instruction in memory |
| wb_dst | input | REG_AW | Destination register of the instruction in writeback |
| wb_wen | input | 1 | Register-write enable of the instruction in writeback |
| fwd_sel_a | output | 2 | Operand origin select for source A |
| fwd_sel_b | output | 2 | Operand origin select for source B |
| hold_pc | output | 1 | Load-use interlock: keep the program counter |
| hold_dec | output | 1 | Load-use interlock: keep the decode register |
| bubble_exe | output | 1 | Load-use interlock: insert a NOP into execute |
| kill_dec | output | 1 | Taken branch: turn the instruction entering decode into a NOP |
| kill_exe | output | 1 | Taken branch: turn the instruction entering execute into a NOP |

## Verification
The hardest situations to reach are the ones where several stages name the same register at once. Examples are a triple match that must resolve by age, a load match arriving together with a taken branch, and register zero matching in every stage with all enables set. Uniformly random 5-bit register numbers would almost never collide. The random stimulus therefore draws register numbers from a small pool (0 to 3), so that collisions, zero destinations and simultaneous matches occur in a large share of vectors. Directed vectors pin down each corner once.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // origin of an operand delivered to the decode-stage operand latch
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EXE = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } opnd_src_e;

  // producers ordered youngest first: index 0 execute, 1 memory, 2 writeback
  localparam int unsigned N_PROD = 3;
  // decode-stage source operands
  localparam int unsigned N_SRC  = 2;
  localparam int unsigned SEL_W  = 2;
endpackage

// File: rtl/hzd_stage_match.sv
module hzd_stage_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              wen,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dst_live;

  // a producer only counts when it really writes a non-zero register
  assign dst_live = wen && (dst != ZERO_REG);
  assign hit      = dst_live && (dst == src);
endmodule

// File: rtl/hzd_src_select.sv
module hzd_src_select
  import hzd_pkg::*;
#(
  parameter int unsigned NP = N_PROD
) (
  input  logic [NP-1:0] hits,
  output opnd_src_e     sel
);
  // walk from the oldest producer to the youngest so the youngest overrides
  always_comb begin
    sel = SRC_RF;
    for (int p = NP - 1; p >= 0; p--) begin
      if (hits[p]) begin
        sel = opnd_src_e'(SEL_W'(p + 1));
      end
    end
  end
endmodule

// File: rtl/hzd_load_interlock.sv
module hzd_load_interlock #(
  parameter int unsigned NS = 2
) (
  input  logic          exe_is_load,
  input  logic          exe_br_taken,
  input  logic [NS-1:0] exe_hits,
  output logic          hold_pc,
  output logic          hold_dec,
  output logic          bubble_exe
);
  logic dep_on_load;
  logic need_stall;

  assign dep_on_load = exe_is_load && (|exe_hits);
  // a taken branch kills the dependent instruction, so no wait is needed
  assign need_stall  = dep_on_load && !exe_br_taken;

  assign hold_pc    = need_stall;
  assign hold_dec   = need_stall;
  assign bubble_exe = need_stall;
endmodule

// File: rtl/hzd_branch_kill.sv
module hzd_branch_kill #(
  parameter int unsigned KILL_DEPTH = 2
) (
  input  logic                  exe_br_taken,
  output logic [KILL_DEPTH-1:0] kill_vec
);
  // one kill per younger instruction already fetched behind the branch
  generate
    for (genvar k = 0; k < KILL_DEPTH; k++) begin : g_kill
      assign kill_vec[k] = exe_br_taken;
    end
  endgenerate
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic [REG_AW-1:0] exe_dst,
  input  logic              exe_wen,
  input  logic              exe_is_load,
  input  logic              exe_br_taken,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic              hold_pc,
  output logic              hold_dec,
  output logic              bubble_exe,
  output logic              kill_dec,
  output logic              kill_exe
);
  localparam int unsigned KILL_DEPTH = 2;

  logic [N_SRC-1:0][REG_AW-1:0]  src_num;
  logic [N_PROD-1:0][REG_AW-1:0] prod_dst;
  logic [N_PROD-1:0]             prod_wen;
  logic [N_SRC-1:0][N_PROD-1:0]  hit;
  opnd_src_e                     sel   [N_SRC];
  logic [N_SRC-1:0]              exe_hit;
  logic [KILL_DEPTH-1:0]         kill_vec;

  assign src_num[0]  = dec_src_a;
  assign src_num[1]  = dec_src_b;
  assign prod_dst[0] = exe_dst;
  assign prod_dst[1] = mem_dst;
  assign prod_dst[2] = wb_dst;
  assign prod_wen[0] = exe_wen;
  assign prod_wen[1] = mem_wen;
  assign prod_wen[2] = wb_wen;

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      for (genvar p = 0; p < N_PROD; p++) begin : g_prod
        hzd_stage_match #(.REG_AW(REG_AW)) match_i (
          .src (src_num[s]),
          .dst (prod_dst[p]),
          .wen (prod_wen[p]),
          .hit (hit[s][p])
        );
      end

      hzd_src_select #(.NP(N_PROD)) select_i (
        .hits (hit[s]),
        .sel  (sel[s])
      );

      assign exe_hit[s] = hit[s][0];
    end
  endgenerate

  hzd_load_interlock #(.NS(N_SRC)) interlock_i (
    .exe_is_load  (exe_is_load),
    .exe_br_taken (exe_br_taken),
    .exe_hits     (exe_hit),
    .hold_pc      (hold_pc),
    .hold_dec     (hold_dec),
    .bubble_exe   (bubble_exe)
  );

  hzd_branch_kill #(.KILL_DEPTH(KILL_DEPTH)) kill_i (
    .exe_br_taken (exe_br_taken),
    .kill_vec     (kill_vec)
  );

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];
  assign kill_dec  = kill_vec[0];
  assign kill_exe  = kill_vec[1];
endmodule

// File: rtl/hzd_fwd_unit_chk.sv
module hzd_fwd_unit_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] dec_src_a,
  input logic [REG_AW-1:0] dec_src_b,
  input logic [REG_AW-1:0] exe_dst,
  input logic              exe_wen,
  input logic              exe_is_load,
  input logic              exe_br_taken,
  input logic [REG_AW-1:0] mem_dst,
  input logic              mem_wen,
  input logic [REG_AW-1:0] wb_dst,
  input logic              wb_wen,
  input logic [1:0]        fwd_sel_a,
  input logic [1:0]        fwd_sel_b,
  input logic              hold_pc,
  input logic              hold_dec,
  input logic              bubble_exe,
  input logic              kill_dec,
  input logic              kill_exe
);
  logic stall_any;
  assign stall_any = hold_pc | hold_dec | bubble_exe;

  always_comb begin
    // R2: a zero source can never be served by a bypass
    p_zero_src_a_r2: assert (dec_src_a != '0 || fwd_sel_a == 2'd0)
      else $error("zero source A forwarded");
    p_zero_src_b_r2: assert (dec_src_b != '0 || fwd_sel_b == 2'd0)
      else $error("zero source B forwarded");
    // R2: a load writing register zero never stalls
    p_zero_load_r2: assert (exe_dst != '0 || !stall_any)
      else $error("stall on zero destination");
    // R3: a live execute match on source A always wins
    p_exe_first_r3: assert (!(exe_wen && exe_dst != '0 && exe_dst == dec_src_a)
                            || fwd_sel_a == 2'd1)
      else $error("execute match lost priority");
    // R4: a selected stage must have its write enable set
    p_sel_wen_r4: assert ((fwd_sel_a != 2'd1 || exe_wen) && (fwd_sel_a != 2'd2 || mem_wen)
                          && (fwd_sel_a != 2'd3 || wb_wen))
      else $error("disabled stage selected");
    // R5: the three interlock controls move together
    p_stall_same_r5: assert (hold_pc == hold_dec && hold_dec == bubble_exe)
      else $error("interlock controls differ");
    // R6: only a load in execute may stall
    p_stall_load_r6: assert (!stall_any || exe_is_load)
      else $error("stall without load");
    // R7: kills follow the taken branch flag
    p_kill_r7: assert (kill_dec == exe_br_taken && kill_exe == exe_br_taken)
      else $error("kill mismatch");
    // R8: no stall while a taken branch flushes
    p_no_stall_br_r8: assert (!(exe_br_taken && stall_any))
      else $error("stall during flush");
  end
endmodule

bind hzd_fwd_unit hzd_fwd_unit_chk #(.REG_AW(REG_AW)) chk_i (
  .dec_src_a    (dec_src_a),
  .dec_src_b    (dec_src_b),
  .exe_dst      (exe_dst),
  .exe_wen      (exe_wen),
  .exe_is_load  (exe_is_load),
  .exe_br_taken (exe_br_taken),
  .mem_dst      (mem_dst),
  .mem_wen      (mem_wen),
  .wb_dst       (wb_dst),
  .wb_wen       (wb_wen),
  .fwd_sel_a    (fwd_sel_a),
  .fwd_sel_b    (fwd_sel_b),
  .hold_pc      (hold_pc),
  .hold_dec     (hold_dec),
  .bubble_exe   (bubble_exe),
  .kill_dec     (kill_dec),
  .kill_exe     (kill_exe)
);

// File: tb/hzd_fwd_unit_tb_top.sv
module hzd_fwd_unit_tb_top;
  localparam int unsigned AW = 5;
  localparam int unsigned N_RAND = 400;
  localparam int unsigned WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] src_a, src_b, e_dst, m_dst, w_dst;
  logic e_wen, e_ld, e_br, m_wen, w_wen;
  logic [1:0] sel_a, sel_b;
  logic h_pc, h_dec, bub, k_dec, k_exe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  hzd_fwd_unit #(.REG_AW(AW)) dut_i (
    .dec_src_a (src_a), .dec_src_b (src_b),
    .exe_dst (e_dst), .exe_wen (e_wen), .exe_is_load (e_ld), .exe_br_taken (e_br),
    .mem_dst (m_dst), .mem_wen (m_wen), .wb_dst (w_dst), .wb_wen (w_wen),
    .fwd_sel_a (sel_a), .fwd_sel_b (sel_b),
    .hold_pc (h_pc), .hold_dec (h_dec), .bubble_exe (bub),
    .kill_dec (k_dec), .kill_exe (k_exe)
  );

  function automatic logic [1:0] ref_sel(input logic [AW-1:0] s);
    if (e_wen && e_dst != 0 && e_dst == s) return 2'd1;
    if (m_wen && m_dst != 0 && m_dst == s) return 2'd2;
    if (w_wen && w_dst != 0 && w_dst == s) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic ref_stall();
    logic dep;
    dep = e_wen && e_dst != 0 && (e_dst == src_a || e_dst == src_b);
    return e_ld && dep && !e_br;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (srcA=%0d srcB=%0d E=%0d/%0b/%0b/%0b M=%0d/%0b W=%0d/%0b)",
               tag, act, exp, src_a, src_b, e_dst, e_wen, e_ld, e_br, m_dst, m_wen, w_dst, w_wen);
    end
  endtask

  task automatic apply(input int a, input int b, input int ed, input bit ew, input bit el,
                       input bit eb, input int md, input bit mw, input int wd, input bit ww);
    @(posedge clk);
    src_a = AW'(a); src_b = AW'(b);
    e_dst = AW'(ed); e_wen = ew; e_ld = el; e_br = eb;
    m_dst = AW'(md); m_wen = mw; w_dst = AW'(wd); w_wen = ww;
    @(negedge clk);
  endtask

  // full comparison against the reference for the present vector
  task automatic check_all(input string ctx);
    cmp({ctx, " R1 R3 sel_a"}, sel_a, ref_sel(src_a));
    cmp({ctx, " R1 R9 sel_b"}, sel_b, ref_sel(src_b));
    cmp({ctx, " R5 hold_pc"}, h_pc, ref_stall());
    cmp({ctx, " R5 hold_dec"}, h_dec, ref_stall());
    cmp({ctx, " R5 bubble_exe"}, bub, ref_stall());
    cmp({ctx, " R7 kill_dec"}, k_dec, e_br);
    cmp({ctx, " R7 kill_exe"}, k_exe, e_br);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [1:0] prev_a;
    seed = 32'd1234;
    void'($urandom(seed));
    src_a = '0; src_b = '0; e_dst = '0; m_dst = '0; w_dst = '0;
    e_wen = 0; e_ld = 0; e_br = 0; m_wen = 0; w_wen = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle: everything quiet
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cmp("idle R1 sel_a", sel_a, 0);
    cmp("idle R5 stall", h_pc, 0);
    cmp("idle R7 kill", k_dec, 0);

    // R1: each single stage selected on its own
    apply(7, 9, 7, 1, 0, 0, 1, 0, 2, 0); cmp("R1 exe only", sel_a, 1);
    apply(7, 9, 1, 0, 0, 0, 9, 1, 2, 0); cmp("R1 mem only", sel_b, 2);
    apply(7, 9, 1, 0, 0, 0, 2, 0, 7, 1); cmp("R1 wb only", sel_a, 3);

    // R3: triple match, then memory over writeback
    apply(5, 5, 5, 1, 0, 0, 5, 1, 5, 1); cmp("R3 triple", sel_a, 1); cmp("R3 triple b", sel_b, 1);
    apply(5, 6, 4, 1, 0, 0, 5, 1, 5, 1); cmp("R3 mem over wb", sel_a, 2);

    // R2: register zero everywhere with all enables and a load
    apply(0, 0, 0, 1, 1, 0, 0, 1, 0, 1);
    cmp("R2 zero sel_a", sel_a, 0); cmp("R2 zero sel_b", sel_b, 0); cmp("R2 zero stall", h_pc, 0);

    // R4: matches with enables low
    apply(3, 3, 3, 0, 1, 0, 3, 0, 3, 0);
    cmp("R4 disabled sel", sel_a, 0); cmp("R4 disabled load stall", bub, 0);

    // R5: load-use on A, then on B
    apply(8, 2, 8, 1, 1, 0, 0, 0, 0, 0);
    cmp("R5 load A hold_pc", h_pc, 1); cmp("R5 load A hold_dec", h_dec, 1); cmp("R5 load A bubble", bub, 1);
    apply(2, 8, 8, 1, 1, 0, 0, 0, 0, 0); cmp("R5 load B stall", h_dec, 1);
    // following cycle: load has moved to memory, forwarded from there
    apply(2, 8, 0, 0, 0, 0, 8, 1, 0, 0);
    cmp("R5 after stall sel", sel_b, 2); cmp("R5 after stall no hold", h_pc, 0);

    // R6: non-load match forwards with no stall; unrelated load no stall
    apply(8, 2, 8, 1, 0, 0, 0, 0, 0, 0); cmp("R6 alu fwd", sel_a, 1); cmp("R6 alu no stall", h_pc, 0);
    apply(4, 2, 8, 1, 1, 0, 0, 0, 0, 0); cmp("R6 unrelated load", bub, 0);

    // R7 and R8: taken branch with a load match, then not taken
    apply(8, 2, 8, 1, 1, 1, 0, 0, 0, 0);
    cmp("R7 taken kill_dec", k_dec, 1); cmp("R7 taken kill_exe", k_exe, 1); cmp("R8 no stall", h_pc, 0);
    apply(8, 2, 8, 1, 0, 0, 0, 0, 0, 0); cmp("R7 not taken", k_exe, 0);

    // R9: changing B alone leaves A's select intact
    apply(6, 1, 0, 0, 0, 0, 6, 1, 1, 1); prev_a = sel_a;
    apply(6, 6, 0, 0, 0, 0, 6, 1, 1, 1); cmp("R9 A independent of B", sel_a, prev_a);

    // random: small register pool forces collisions
    for (int i = 0; i < N_RAND; i++) begin
      apply($urandom_range(3), $urandom_range(3), $urandom_range(3), 1'($urandom),
            1'($urandom), ($urandom_range(7) == 0), $urandom_range(3), 1'($urandom),
            $urandom_range(3), 1'($urandom));
      check_all("rand");
    end
    // random: full register range
    for (int i = 0; i < N_RAND / 4; i++) begin
      apply($urandom_range(31), $urandom_range(31), $urandom_range(31), 1'($urandom),
            1'($urandom), 1'($urandom), $urandom_range(31), 1'($urandom),
            $urandom_range(31), 1'($urandom));
      check_all("wide");
    end
    finish_run();
  end
endmodule